// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned or two's-complement operands and a carry-in, all without a clock. The operand is split into groups of four bits. Each group forms its own bit carries as flat sums of products of bit generate and propagate terms. Each group also reduces its bits to one group propagate and one group generate. A second lookahead level takes those group terms and the carry-in and produces the carry into every group and the final carry-out. No group reads another group's carry-out, so the worst path is two lookahead levels deep and does not grow by one group delay per group.

The bit generate is `a & b` and the bit propagate is `a | b`. The block also exposes a block-wide propagate and a block-wide generate, so that a third lookahead level can be placed above several of these adders. The default width is 16 bits. A 32-bit variant, made of eight groups, is obtained by setting `WIDTH` to 32.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `a + b + cin`.
- R2: `cout` equals bit `WIDTH` of `a + b + cin`.
- R3: `blk_p` is 1 exactly when every bit position has `a` or `b` set.
- R4: `blk_g` is 1 exactly when `a + b` with no carry-in overflows `WIDTH` bits.
- R5: `cout` equals `blk_g | (blk_p & cin)`.
- R6: The carry into each four-bit group, starting at bit 4k, equals the carry out of bits 0 to 4k-1. This includes a carry that propagates from `cin` through every bit, for example all ones plus zero with `cin` = 1, which gives `sum` = 0 and `cout` = 1.
- R7: With `WIDTH` = 32 (eight groups), R1 to R5 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| blk_p | output | 1 | Block propagate, for a higher lookahead level |
| blk_g | output | 1 | Block generate, for a higher lookahead level |

## Verification
Immediate assertions in the adder are evaluated whenever an input changes. They check the sum and carry-out against a plain addition. They check that the carry-out agrees with the block propagate and generate. They also check that each carry from the second level matches the carry-out that the group below it computes locally, which that group otherwise leaves unused. The block terms themselves, and a propagate chain that runs from `cin` through every group, can only be shown by the bench's directed operand patterns. The same holds for the eight-group configuration.

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             blk_p,
  output logic             blk_g
);
  localparam int GW = 4;
  localparam int NG = WIDTH / GW;

  // Flat sum of products for the carry into position j (j >= 1):
  // OR over k<j of g[k] & p[k+1..j-1], plus p[0..j-1] & c0.
  function automatic logic carry_at(input logic [WIDTH-1:0] g,
                                    input logic [WIDTH-1:0] p,
                                    input logic c0, input int j);
    logic acc, prod;
    acc  = 1'b0;
    prod = 1'b1;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (k < j) begin
        acc  = acc | (g[k] & prod);
        prod = prod & p[k];
      end
    end
    return acc | (prod & c0);
  endfunction

  logic [WIDTH-1:0] bg, bp;
  logic [NG-1:0]    grp_g, grp_p;
  logic [NG:0]      gc;
  logic [NG-1:0]    grp_co;

  assign bg = a & b;
  assign bp = a | b;

  genvar gi, bi;
  generate
    for (gi = 0; gi < NG; gi++) begin : g_grp
      logic [GW-1:0] sg, sp;
      logic [GW:0]   lc;
      assign sg = bg[gi*GW +: GW];
      assign sp = bp[gi*GW +: GW];
      assign grp_p[gi] = &sp;
      assign grp_g[gi] = carry_at(WIDTH'(sg), WIDTH'(sp), 1'b0, GW);
      assign lc[0] = gc[gi];
      for (bi = 1; bi <= GW; bi++) begin : g_bit
        assign lc[bi] = carry_at(WIDTH'(sg), WIDTH'(sp), gc[gi], bi);
      end
      assign sum[gi*GW +: GW] = a[gi*GW +: GW] ^ b[gi*GW +: GW] ^ lc[GW-1:0];
      assign grp_co[gi] = lc[GW];
    end

    assign gc[0] = cin;
    for (gi = 1; gi <= NG; gi++) begin : g_top
      assign gc[gi] = carry_at(WIDTH'(grp_g), WIDTH'(grp_p), cin, gi);
    end
  endgenerate

  assign cout  = gc[NG];
  assign blk_p = &grp_p;
  assign blk_g = carry_at(WIDTH'(grp_g), WIDTH'(grp_p), 1'b0, NG);

  always_comb begin
    assert_sum_R1 : assert (sum == WIDTH'(a + b + WIDTH'(cin)))
      else $error("sum mismatch");
    assert_cout_R2 : assert (cout == (({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)) >> WIDTH))
      else $error("cout mismatch");
    assert_block_terms_R5 : assert (cout == (blk_g | (blk_p & cin)))
      else $error("block terms disagree with cout");
    assert_group_link_R6 : assert (grp_co == gc[NG:1])
      else $error("second-level carry differs from group carry-out");
  end

  initial begin
    assert_width_R7 : assert (WIDTH % GW == 0 && WIDTH >= GW)
      else $error("WIDTH must be a multiple of four");
  end
endmodule

// File: tb/sim_cla_two_level_adder.sv
module sim_cla_two_level_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int W2 = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, sum;
  logic          cin, cout, blk_p, blk_g;
  logic [W2-1:0] a2, b2, sum2;
  logic          cin2, cout2, blk_p2, blk_g2;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cla_two_level_adder #(.WIDTH(W)) u0 (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .blk_p(blk_p), .blk_g(blk_g));

  cla_two_level_adder #(.WIDTH(W2)) u1 (
    .a(a2), .b(b2), .cin(cin2), .sum(sum2), .cout(cout2), .blk_p(blk_p2), .blk_g(blk_g2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] full, nocin;
    a = x; b = y; cin = c;
    @(negedge clk);
    full  = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    nocin = {1'b0, x} + {1'b0, y};
    chk("R1 sum", 64'(sum), 64'(full[W-1:0]));
    chk("R2 cout", 64'(cout), 64'(full[W]));
    chk("R3 blk_p", 64'(blk_p), 64'(&(x | y)));
    chk("R4 blk_g", 64'(blk_g), 64'(nocin[W]));
    chk("R5 cout from block terms", 64'(cout), 64'(blk_g | (blk_p & c)));
  endtask

  task automatic apply32(input logic [W2-1:0] x, input logic [W2-1:0] y, input logic c);
    logic [W2:0] full, nocin;
    a2 = x; b2 = y; cin2 = c;
    @(negedge clk);
    full  = {1'b0, x} + {1'b0, y} + (W2+1)'(c);
    nocin = {1'b0, x} + {1'b0, y};
    chk("R7 sum32", 64'(sum2), 64'(full[W2-1:0]));
    chk("R7 cout32", 64'(cout2), 64'(full[W2]));
    chk("R7 blk_p32", 64'(blk_p2), 64'(&(x | y)));
    chk("R7 blk_g32", 64'(blk_g2), 64'(nocin[W2]));
  endtask

  task automatic t_idle;
    apply16('0, '0, 1'b0);
    apply32('0, '0, 1'b0);
  endtask

  task automatic t_propagate_chain;
    // R6: carry from cin runs through every group
    apply16(16'hFFFF, 16'h0000, 1'b1);
    chk("R6 chain sum zero", 64'(sum), 64'h0);
    apply16(16'h0000, 16'hFFFF, 1'b1);
    apply16(16'h0FFF, 16'h0000, 1'b1);
    chk("R6 carry into top group", 64'(sum), 64'h1000);
    apply16(16'h00FF, 16'h0000, 1'b1);
    apply16(16'h5555, 16'hAAAA, 1'b0);
    apply16(16'h5555, 16'hAAAA, 1'b1);
  endtask

  task automatic t_generate;
    apply16(16'h8000, 16'h8000, 1'b0);
    apply16(16'h0008, 16'h0008, 1'b0);
    chk("R6 group0 generate into group1", 64'(sum), 64'h0010);
    apply16(16'hFFFF, 16'hFFFF, 1'b1);
    apply16(16'h7FFF, 16'h0001, 1'b0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++)
      apply16(W'($urandom), W'($urandom), 1'($urandom));
  endtask

  task automatic t_wide;
    apply32('1, '0, 1'b1);
    apply32(32'h0000_FFFF, 32'h0000_0001, 1'b0);
    for (int i = 0; i < 200; i++)
      apply32($urandom, $urandom, 1'($urandom));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    a2 = '0; b2 = '0; cin2 = 1'b0;
    @(negedge clk);
    t_idle();
    t_propagate_chain();
    t_generate();
    t_random();
    t_wide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule